// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode controller of a small microcontroller that runs from a slow sub-clock. It keeps a two-bit mode state that takes one of four values: reset, subactive, subsleep and hardware standby. From that state it drives the clock-gate enables for the CPU, for a group of sub-clock timers, for the watchdogs, for the remaining peripherals and for the main oscillator. It also drives reset strobes for the serial interface and for the ADC. Both of those blocks lose their contents during subsleep.

The CPU signals that it executed a sleep instruction by raising `sleep_exec` for one cycle. Subsleep is entered only when three configuration bits hold a fixed combination. While the block is in subsleep, any qualified interrupt wakes it. It then returns to subactive and asks the CPU to start interrupt exception processing. The pins for reset, manual reset and standby override the normal flow. Every asynchronous pin input passes through a synchronizer on the sub-clock before the state machine acts on it.

Top module: `lpm_sequencer`

## Requirements
- R1: While `por_n` is low, and until `rst_pin_n` and `mrst_pin_n` are both seen high, `mode` is 2'b00 (reset). In this state `cpu_clk_en` is 0, `osc_en` is 1, and `sci_rst` and `adc_rst` are 1. The block then moves to subactive (2'b01).
- R2: A `sleep_exec` pulse in subactive with `cfg_stby_sel`=0, `cfg_lowspd_on`=1 and `cfg_wdt_presel`=1 moves `mode` to 2'b10 (subsleep) at the next clock edge.
- R3: A `sleep_exec` pulse in subactive with any other value of those three bits is ignored. `mode` stays 2'b01 and `cpu_clk_en` stays 1.
- R4: In subsleep, `cpu_clk_en`, `osc_en` and every `per_clk_en` bit are 0. Every `tmr_clk_en` and `wdt_clk_en` bit is 1.
- R5: In subactive, the CPU, timer, watchdog and peripheral enables are all 1 and `osc_en` is 0.
- R6: In subsleep, any of the following wakes the block to subactive: `nmi_pin`, or IRQ line i with `irq_en[i]`=1 and `irq_pinfn[i]`=1, or peripheral source j with `per_irq_en[j]`=1 while `cpu_irq_mask`=0. `irq_exc_req` is high for exactly the one cycle that follows the wake edge.
- R7: An IRQ line whose enable bit or pin-function bit is 0 does not wake the block. A peripheral source whose enable bit is 0, or that arrives while `cpu_irq_mask`=1, does not wake it either. In both cases `mode` stays 2'b10 and `irq_exc_req` stays 0.
- R8: Whenever subsleep is left, `sci_rst` and `adc_rst` are high for exactly RST_PULSE_LEN cycles after the exit edge and then fall.
- R9: `stby_pin_n` low moves the block from any mode to 2'b11 (hardware standby). There, every clock enable is 0 and both reset strobes are 1. When the pin returns high, the block goes to 2'b00.
- R10: `rst_pin_n` or `mrst_pin_n` low while in subsleep moves `mode` to 2'b00.
- R11: A pin change is acted on at the (SYNC_STAGES+1)-th rising edge after it and not earlier. `per_irq` and `sleep_exec` are synchronous and are acted on at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sub | input | 1 | Sub-clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_exec | input | 1 | One-cycle pulse: CPU executed a sleep instruction |
| cfg_stby_sel | input | 1 | Standby-select control bit |
| cfg_lowspd_on | input | 1 | Low-speed-on control bit |
| cfg_wdt_presel | input | 1 | Watchdog prescaler-select control bit |
| nmi_pin | input | 1 | Non-maskable interrupt pin, active high, asynchronous |
| irq_pin | input | N_IRQ | External interrupt pins, active high, asynchronous |
| irq_en | input | N_IRQ | Per-line interrupt enable |
| irq_pinfn | input | N_IRQ | Per-line pin-function select (1 = interrupt input) |
| per_irq | input | N_PER | Internal peripheral interrupt requests, synchronous |
| per_irq_en | input | N_PER | Per-source peripheral interrupt enable |
| cpu_irq_mask | input | 1 | CPU mask blocking peripheral interrupts |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| mrst_pin_n | input | 1 | Manual reset pin, active low, asynchronous |
| stby_pin_n | input | 1 | Standby pin, active low, asynchronous |
| mode | output | 2 | Mode: 00 reset, 01 subactive, 10 subsleep, 11 hardware standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| tmr_clk_en | output | N_TMR | Sub-clock timer clock enables |
| wdt_clk_en | output | N_WDT | Watchdog clock enables |
| per_clk_en | output | N_OTHER | Other peripheral clock enables |
| sci_rst | output | 1 | Serial interface reset strobe |
| adc_rst | output | 1 | ADC reset strobe |
| irq_exc_req | output | 1 | Request to start interrupt exception processing |

## Verification
The bench builds the block with its defaults: eight IRQ lines, four peripheral sources, four timers, two watchdogs, six other peripherals, a two-stage synchronizer and a three-cycle reset pulse. With these values the bench can walk every IRQ line and every peripheral source through its disqualified and qualified cases. It can count the pulse length to the exact edge and show that the pin latency is three edges, with no wake one edge early. The standby and reset paths are driven from both subactive and subsleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      MODE_RESET  = 2'b00,
      MODE_SUBACT = 2'b01,
      MODE_SUBSLP = 2'b10,
      MODE_HWSTBY = 2'b11
   } lpm_mode_e;

   // control-bit pattern that permits subsleep entry
   localparam logic LPM_STBY_SEL_REQ  = 1'b0;
   localparam logic LPM_LOWSPD_REQ    = 1'b1;
   localparam logic LPM_WDT_PRESEL_REQ = 1'b1;

   typedef struct packed {
      logic cpu;
      logic osc;
      logic tmr;
      logic wdt;
      logic per;
      logic rst_hold;
   } lpm_gate_t;

   function automatic lpm_gate_t lpm_gate_of(lpm_mode_e m);
      lpm_gate_t g;
      case (m)
         MODE_RESET:  g = '{cpu: 1'b0, osc: 1'b1, tmr: 1'b1, wdt: 1'b1, per: 1'b0, rst_hold: 1'b1};
         MODE_SUBACT: g = '{cpu: 1'b1, osc: 1'b0, tmr: 1'b1, wdt: 1'b1, per: 1'b1, rst_hold: 1'b0};
         MODE_SUBSLP: g = '{cpu: 1'b0, osc: 1'b0, tmr: 1'b1, wdt: 1'b1, per: 1'b0, rst_hold: 1'b0};
         default:     g = '{cpu: 1'b0, osc: 1'b0, tmr: 1'b0, wdt: 1'b0, per: 1'b0, rst_hold: 1'b1};
      endcase
      return g;
   endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
   parameter int unsigned N_IRQ        = 8,
   parameter int unsigned N_PER        = 4,
   parameter bit          PER_MASKABLE = 1'b1
) (
   input  logic             nmi,
   input  logic [N_IRQ-1:0] irq,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic [N_IRQ-1:0] irq_pinfn,
   input  logic [N_PER-1:0] per_irq,
   input  logic [N_PER-1:0] per_irq_en,
   input  logic             cpu_mask,
   output logic             wake
);

   logic [N_IRQ-1:0] irq_ok;
   logic [N_PER-1:0] per_ok;
   logic             per_gate;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      assign irq_ok[i] = irq[i] & irq_en[i] & irq_pinfn[i];
   end

   for (genvar j = 0; j < N_PER; j++) begin : g_per
      assign per_ok[j] = per_irq[j] & per_irq_en[j];
   end

   if (PER_MASKABLE) begin : g_masked
      assign per_gate = ~cpu_mask;
   end else begin : g_unmasked
      assign per_gate = 1'b1;
   end

   assign wake = nmi | (|irq_ok) | ((|per_ok) & per_gate);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_exec,
   input  logic      cfg_stby_sel,
   input  logic      cfg_lowspd_on,
   input  logic      cfg_wdt_presel,
   input  logic      wake,
   input  logic      rst_pins_ok,
   input  logic      stby_ok,
   output lpm_mode_e mode,
   output logic      exc_req,
   output logic      exit_sleep
);

   lpm_mode_e mode_q, mode_d;
   logic      entry_ok;

   assign entry_ok = sleep_exec
                   & (cfg_stby_sel   == LPM_STBY_SEL_REQ)
                   & (cfg_lowspd_on  == LPM_LOWSPD_REQ)
                   & (cfg_wdt_presel == LPM_WDT_PRESEL_REQ);

   always_comb begin
      mode_d = mode_q;
      if (!stby_ok) begin
         mode_d = MODE_HWSTBY;
      end else if (mode_q == MODE_HWSTBY) begin
         mode_d = MODE_RESET;
      end else if (!rst_pins_ok) begin
         mode_d = MODE_RESET;
      end else begin
         case (mode_q)
            MODE_RESET:  mode_d = MODE_SUBACT;
            MODE_SUBACT: if (entry_ok) mode_d = MODE_SUBSLP;
            MODE_SUBSLP: if (wake)     mode_d = MODE_SUBACT;
            default:     mode_d = MODE_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_RESET;
         exc_req <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         exc_req <= (mode_q == MODE_SUBSLP) && (mode_d == MODE_SUBACT);
      end
   end

   assign exit_sleep = (mode_q == MODE_SUBSLP) && (mode_d != MODE_SUBSLP);
   assign mode       = mode_q;

endmodule

// File: rtl/lpm_gate_ctl.sv
module lpm_gate_ctl
   import lpm_pkg::*;
#(
   parameter int unsigned N_TMR         = 4,
   parameter int unsigned N_WDT         = 2,
   parameter int unsigned N_OTHER       = 6,
   parameter int unsigned RST_PULSE_LEN = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  lpm_mode_e          mode,
   input  logic               exit_sleep,
   output logic               cpu_clk_en,
   output logic               osc_en,
   output logic [N_TMR-1:0]   tmr_clk_en,
   output logic [N_WDT-1:0]   wdt_clk_en,
   output logic [N_OTHER-1:0] per_clk_en,
   output logic               sci_rst,
   output logic               adc_rst
);

   localparam int unsigned CW = $clog2(RST_PULSE_LEN + 1);

   lpm_gate_t    g;
   logic [CW-1:0] pulse_cnt;
   logic          pulse_on;

   assign g = lpm_gate_of(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_cnt <= '0;
      end else if (exit_sleep) begin
         pulse_cnt <= CW'(RST_PULSE_LEN);
      end else if (pulse_cnt != '0) begin
         pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   assign pulse_on   = (pulse_cnt != '0);
   assign cpu_clk_en = g.cpu;
   assign osc_en     = g.osc;

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      assign tmr_clk_en[t] = g.tmr;
   end
   for (genvar w = 0; w < N_WDT; w++) begin : g_wdt
      assign wdt_clk_en[w] = g.wdt;
   end
   for (genvar p = 0; p < N_OTHER; p++) begin : g_per
      assign per_clk_en[p] = g.per;
   end

   assign sci_rst = g.rst_hold | pulse_on;
   assign adc_rst = g.rst_hold | pulse_on;

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
   import lpm_pkg::*;
#(
   parameter int unsigned N_IRQ         = 8,
   parameter int unsigned N_PER         = 4,
   parameter int unsigned N_TMR         = 4,
   parameter int unsigned N_WDT         = 2,
   parameter int unsigned N_OTHER       = 6,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned RST_PULSE_LEN = 3,
   parameter bit          PER_MASKABLE  = 1'b1
) (
   input  logic               clk_sub,
   input  logic               por_n,
   input  logic               sleep_exec,
   input  logic               cfg_stby_sel,
   input  logic               cfg_lowspd_on,
   input  logic               cfg_wdt_presel,
   input  logic               nmi_pin,
   input  logic [N_IRQ-1:0]   irq_pin,
   input  logic [N_IRQ-1:0]   irq_en,
   input  logic [N_IRQ-1:0]   irq_pinfn,
   input  logic [N_PER-1:0]   per_irq,
   input  logic [N_PER-1:0]   per_irq_en,
   input  logic               cpu_irq_mask,
   input  logic               rst_pin_n,
   input  logic               mrst_pin_n,
   input  logic               stby_pin_n,
   output logic [1:0]         mode,
   output logic               cpu_clk_en,
   output logic               osc_en,
   output logic [N_TMR-1:0]   tmr_clk_en,
   output logic [N_WDT-1:0]   wdt_clk_en,
   output logic [N_OTHER-1:0] per_clk_en,
   output logic               sci_rst,
   output logic               adc_rst,
   output logic               irq_exc_req
);

   // synchronizer vector layout: {stby_n, mrst_n, rst_n, irq[N_IRQ-1:0], nmi}
   localparam int unsigned SYNC_W = N_IRQ + 4;
   localparam logic [SYNC_W-1:0] SYNC_INIT = {1'b1, {(SYNC_W-1){1'b0}}};

   if (N_IRQ < 1 || N_IRQ > 32) begin : g_bad_irq
      $error("lpm_sequencer: N_IRQ out of range");
   end
   if (N_PER < 1) begin : g_bad_per
      $error("lpm_sequencer: N_PER must be at least 1");
   end
   if (N_TMR < 1 || N_WDT < 1 || N_OTHER < 1) begin : g_bad_grp
      $error("lpm_sequencer: clock groups must be non-empty");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpm_sequencer: SYNC_STAGES must be at least 2");
   end
   if (RST_PULSE_LEN < 1) begin : g_bad_pulse
      $error("lpm_sequencer: RST_PULSE_LEN must be at least 1");
   end

   logic [SYNC_W-1:0] pins_raw, pins_s;
   logic              nmi_s, rst_s, mrst_s, stby_s;
   logic [N_IRQ-1:0]  irq_s;
   logic              wake;
   logic              exit_sleep;
   lpm_mode_e         mode_e;

   assign pins_raw = {stby_pin_n, mrst_pin_n, rst_pin_n, irq_pin, nmi_pin};

   lpm_sync #(
      .W      (SYNC_W),
      .STAGES (SYNC_STAGES),
      .INIT   (SYNC_INIT)
   ) i_sync (
      .clk   (clk_sub),
      .rst_n (por_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign nmi_s  = pins_s[0];
   assign irq_s  = pins_s[N_IRQ:1];
   assign rst_s  = pins_s[N_IRQ+1];
   assign mrst_s = pins_s[N_IRQ+2];
   assign stby_s = pins_s[N_IRQ+3];

   lpm_wake_qual #(
      .N_IRQ        (N_IRQ),
      .N_PER        (N_PER),
      .PER_MASKABLE (PER_MASKABLE)
   ) i_wake (
      .nmi        (nmi_s),
      .irq        (irq_s),
      .irq_en     (irq_en),
      .irq_pinfn  (irq_pinfn),
      .per_irq    (per_irq),
      .per_irq_en (per_irq_en),
      .cpu_mask   (cpu_irq_mask),
      .wake       (wake)
   );

   lpm_fsm i_fsm (
      .clk            (clk_sub),
      .rst_n          (por_n),
      .sleep_exec     (sleep_exec),
      .cfg_stby_sel   (cfg_stby_sel),
      .cfg_lowspd_on  (cfg_lowspd_on),
      .cfg_wdt_presel (cfg_wdt_presel),
      .wake           (wake),
      .rst_pins_ok    (rst_s & mrst_s),
      .stby_ok        (stby_s),
      .mode           (mode_e),
      .exc_req        (irq_exc_req),
      .exit_sleep     (exit_sleep)
   );

   lpm_gate_ctl #(
      .N_TMR         (N_TMR),
      .N_WDT         (N_WDT),
      .N_OTHER       (N_OTHER),
      .RST_PULSE_LEN (RST_PULSE_LEN)
   ) i_gate (
      .clk        (clk_sub),
      .rst_n      (por_n),
      .mode       (mode_e),
      .exit_sleep (exit_sleep),
      .cpu_clk_en (cpu_clk_en),
      .osc_en     (osc_en),
      .tmr_clk_en (tmr_clk_en),
      .wdt_clk_en (wdt_clk_en),
      .per_clk_en (per_clk_en),
      .sci_rst    (sci_rst),
      .adc_rst    (adc_rst)
   );

   assign mode = mode_e;

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
   parameter int unsigned N_TMR   = 4,
   parameter int unsigned N_WDT   = 2,
   parameter int unsigned N_OTHER = 6
) (
   input logic               clk_sub,
   input logic               por_n,
   input logic               sleep_exec,
   input logic               cfg_stby_sel,
   input logic               cfg_lowspd_on,
   input logic               cfg_wdt_presel,
   input logic [1:0]         mode,
   input logic               cpu_clk_en,
   input logic               osc_en,
   input logic [N_TMR-1:0]   tmr_clk_en,
   input logic [N_WDT-1:0]   wdt_clk_en,
   input logic [N_OTHER-1:0] per_clk_en,
   input logic               sci_rst,
   input logic               adc_rst,
   input logic               irq_exc_req
);

   // R2
   sleep_entry_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      (mode == 2'b10 && $past(mode) == 2'b01) |->
      $past(sleep_exec && !cfg_stby_sel && cfg_lowspd_on && cfg_wdt_presel));

   // R4
   subsleep_gate_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      (mode == 2'b10) |-> (!cpu_clk_en && !osc_en && per_clk_en == '0
                           && (&tmr_clk_en) && (&wdt_clk_en)));

   // R6
   wake_req_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      irq_exc_req |-> (mode == 2'b01 && $past(mode) == 2'b10));

   // R6
   wake_req_pulse_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      irq_exc_req |=> !irq_exc_req);

   // R8
   exit_strobe_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      ($past(mode) == 2'b10 && mode != 2'b10) |-> (sci_rst && adc_rst));

   // R9
   standby_gate_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      (mode == 2'b11) |-> (!cpu_clk_en && !osc_en && tmr_clk_en == '0
                           && wdt_clk_en == '0 && sci_rst));

   // R9
   standby_exit_chk: assert property (@(posedge clk_sub) disable iff (!por_n)
      ($past(mode) == 2'b11 && mode != 2'b11) |-> (mode == 2'b00));

endmodule

bind lpm_sequencer lpm_sequencer_chk #(
   .N_TMR   (N_TMR),
   .N_WDT   (N_WDT),
   .N_OTHER (N_OTHER)
) i_lpm_chk (
   .clk_sub        (clk_sub),
   .por_n          (por_n),
   .sleep_exec     (sleep_exec),
   .cfg_stby_sel   (cfg_stby_sel),
   .cfg_lowspd_on  (cfg_lowspd_on),
   .cfg_wdt_presel (cfg_wdt_presel),
   .mode           (mode),
   .cpu_clk_en     (cpu_clk_en),
   .osc_en         (osc_en),
   .tmr_clk_en     (tmr_clk_en),
   .wdt_clk_en     (wdt_clk_en),
   .per_clk_en     (per_clk_en),
   .sci_rst        (sci_rst),
   .adc_rst        (adc_rst),
   .irq_exc_req    (irq_exc_req)
);

// File: tb/test_lpm_sequencer.sv
`timescale 1ns/1ps
module test_lpm_sequencer;

   localparam int N_IRQ = 8, N_PER = 4, N_TMR = 4, N_WDT = 2, N_OTHER = 6;
   localparam int SYNC_STAGES = 2, RST_PULSE_LEN = 3;
   localparam int LAT = SYNC_STAGES + 1;

   logic clk_sub = 1'b0;
   logic por_n = 1'b0;
   logic sleep_exec = 1'b0;
   logic cfg_stby_sel = 1'b0, cfg_lowspd_on = 1'b1, cfg_wdt_presel = 1'b1;
   logic nmi_pin = 1'b0;
   logic [N_IRQ-1:0] irq_pin = '0, irq_en = '1, irq_pinfn = '1;
   logic [N_PER-1:0] per_irq = '0, per_irq_en = '1;
   logic cpu_irq_mask = 1'b0;
   logic rst_pin_n = 1'b1, mrst_pin_n = 1'b1, stby_pin_n = 1'b1;
   logic [1:0] mode;
   logic cpu_clk_en, osc_en, sci_rst, adc_rst, irq_exc_req;
   logic [N_TMR-1:0] tmr_clk_en;
   logic [N_WDT-1:0] wdt_clk_en;
   logic [N_OTHER-1:0] per_clk_en;

   int total = 0, bad = 0;

   always #2.5 clk_sub = ~clk_sub;

   lpm_sequencer #(
      .N_IRQ(N_IRQ), .N_PER(N_PER), .N_TMR(N_TMR), .N_WDT(N_WDT), .N_OTHER(N_OTHER),
      .SYNC_STAGES(SYNC_STAGES), .RST_PULSE_LEN(RST_PULSE_LEN), .PER_MASKABLE(1'b1)
   ) i_lpm_sequencer (
      .clk_sub(clk_sub), .por_n(por_n), .sleep_exec(sleep_exec),
      .cfg_stby_sel(cfg_stby_sel), .cfg_lowspd_on(cfg_lowspd_on), .cfg_wdt_presel(cfg_wdt_presel),
      .nmi_pin(nmi_pin), .irq_pin(irq_pin), .irq_en(irq_en), .irq_pinfn(irq_pinfn),
      .per_irq(per_irq), .per_irq_en(per_irq_en), .cpu_irq_mask(cpu_irq_mask),
      .rst_pin_n(rst_pin_n), .mrst_pin_n(mrst_pin_n), .stby_pin_n(stby_pin_n),
      .mode(mode), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .tmr_clk_en(tmr_clk_en),
      .wdt_clk_en(wdt_clk_en), .per_clk_en(per_clk_en), .sci_rst(sci_rst), .adc_rst(adc_rst),
      .irq_exc_req(irq_exc_req)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk_sub);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_gates(input string req, input logic [1:0] m);
      chk(req, "mode", 32'(mode), 32'(m));
      case (m)
         2'b00: begin
            chk(req, "cpu_clk_en", 32'(cpu_clk_en), 0); chk(req, "osc_en", 32'(osc_en), 1);
            chk(req, "sci_rst", 32'(sci_rst), 1);       chk(req, "adc_rst", 32'(adc_rst), 1);
         end
         2'b01: begin
            chk(req, "cpu_clk_en", 32'(cpu_clk_en), 1); chk(req, "osc_en", 32'(osc_en), 0);
            chk(req, "tmr", 32'(tmr_clk_en), 32'hF);   chk(req, "wdt", 32'(wdt_clk_en), 32'h3);
            chk(req, "per", 32'(per_clk_en), 32'h3F);
         end
         2'b10: begin
            chk(req, "cpu_clk_en", 32'(cpu_clk_en), 0); chk(req, "osc_en", 32'(osc_en), 0);
            chk(req, "tmr", 32'(tmr_clk_en), 32'hF);   chk(req, "wdt", 32'(wdt_clk_en), 32'h3);
            chk(req, "per", 32'(per_clk_en), 0);
         end
         default: begin
            chk(req, "cpu_clk_en", 32'(cpu_clk_en), 0); chk(req, "osc_en", 32'(osc_en), 0);
            chk(req, "tmr", 32'(tmr_clk_en), 0);       chk(req, "wdt", 32'(wdt_clk_en), 0);
            chk(req, "per", 32'(per_clk_en), 0);       chk(req, "sci_rst", 32'(sci_rst), 1);
         end
      endcase
   endtask

   task automatic pulse_sleep();
      sleep_exec = 1'b1;
      step(1);
      sleep_exec = 1'b0;
   endtask

   task automatic enter_sleep(input string req);
      step(LAT + 1);
      pulse_sleep();
      chk(req, "entered subsleep", 32'(mode), 32'h2);
   endtask

   task automatic t_reset();
      step(2);
      chk_gates("R1", 2'b00);
      por_n = 1'b1;
      chk_gates("R1", 2'b00);
      step(LAT);
      chk_gates("R1", 2'b01);
      chk_gates("R5", 2'b01);
   endtask

   task automatic t_bad_sleep();
      for (int k = 0; k < 3; k++) begin
         cfg_stby_sel   = (k == 0);
         cfg_lowspd_on  = (k != 1);
         cfg_wdt_presel = (k != 2);
         pulse_sleep();
         chk("R3", "mode after mismatched sleep", 32'(mode), 32'h1);
         chk("R3", "cpu_clk_en", 32'(cpu_clk_en), 1);
      end
      cfg_stby_sel = 1'b0; cfg_lowspd_on = 1'b1; cfg_wdt_presel = 1'b1;
   endtask

   task automatic t_nmi_wake();
      enter_sleep("R2");
      chk_gates("R4", 2'b10);
      nmi_pin = 1'b1;
      step(LAT - 1);
      chk("R11", "no wake before sync latency", 32'(mode), 32'h2);
      step(1);
      chk("R11", "wake at sync latency", 32'(mode), 32'h1);
      chk("R6", "irq_exc_req on wake", 32'(irq_exc_req), 1);
      chk("R8", "sci_rst pulse c1", 32'(sci_rst), 1);
      chk_gates("R5", 2'b01);
      nmi_pin = 1'b0;
      step(1);
      chk("R6", "irq_exc_req single cycle", 32'(irq_exc_req), 0);
      chk("R8", "adc_rst pulse c2", 32'(adc_rst), 1);
      step(1);
      chk("R8", "sci_rst pulse c3", 32'(sci_rst), 1);
      step(1);
      chk("R8", "sci_rst ended", 32'(sci_rst), 0);
      chk("R8", "adc_rst ended", 32'(adc_rst), 0);
   endtask

   task automatic t_irq_wake();
      for (int i = 0; i < N_IRQ; i++) begin
         enter_sleep("R2");
         irq_pinfn = ~(N_IRQ'(1) << i);
         irq_pin = N_IRQ'(1) << i;
         step(LAT + 2);
         chk("R7", $sformatf("irq%0d pinfn=0 ignored", i), 32'(mode), 32'h2);
         chk("R7", "no exc req", 32'(irq_exc_req), 0);
         irq_pinfn = '1;
         irq_en = ~(N_IRQ'(1) << i);
         step(LAT + 2);
         chk("R7", $sformatf("irq%0d en=0 ignored", i), 32'(mode), 32'h2);
         irq_en = '1;
         step(1);
         chk("R6", $sformatf("irq%0d wakes", i), 32'(mode), 32'h1);
         chk("R6", "exc req", 32'(irq_exc_req), 1);
         irq_pin = '0;
      end
   endtask

   task automatic t_per_wake();
      for (int j = 0; j < N_PER; j++) begin
         enter_sleep("R2");
         per_irq_en = ~(N_PER'(1) << j);
         per_irq = N_PER'(1) << j;
         step(2);
         chk("R7", $sformatf("per%0d en=0 ignored", j), 32'(mode), 32'h2);
         per_irq_en = '1;
         cpu_irq_mask = 1'b1;
         step(2);
         chk("R7", $sformatf("per%0d masked ignored", j), 32'(mode), 32'h2);
         chk("R7", "no exc req", 32'(irq_exc_req), 0);
         cpu_irq_mask = 1'b0;
         step(1);
         chk("R11", $sformatf("per%0d wakes next edge", j), 32'(mode), 32'h1);
         chk("R6", "exc req", 32'(irq_exc_req), 1);
         per_irq = '0;
      end
   endtask

   task automatic t_reset_exit();
      enter_sleep("R2");
      rst_pin_n = 1'b0;
      step(LAT);
      chk("R10", "reset pin exits subsleep", 32'(mode), 32'h0);
      chk("R8", "sci_rst held", 32'(sci_rst), 1);
      rst_pin_n = 1'b1;
      step(LAT);
      chk("R1", "back to subactive", 32'(mode), 32'h1);
      enter_sleep("R2");
      mrst_pin_n = 1'b0;
      step(LAT);
      chk("R10", "manual reset exits subsleep", 32'(mode), 32'h0);
      mrst_pin_n = 1'b1;
      step(LAT);
      chk("R1", "back to subactive", 32'(mode), 32'h1);
   endtask

   task automatic t_standby();
      stby_pin_n = 1'b0;
      step(LAT);
      chk_gates("R9", 2'b11);
      stby_pin_n = 1'b1;
      step(LAT);
      chk("R9", "standby exits to reset", 32'(mode), 32'h0);
      step(1);
      chk("R9", "then subactive", 32'(mode), 32'h1);
      enter_sleep("R2");
      stby_pin_n = 1'b0;
      step(LAT);
      chk_gates("R9", 2'b11);
      stby_pin_n = 1'b1;
      step(LAT + 1);
      chk("R9", "subactive after standby", 32'(mode), 32'h1);
   endtask

   initial begin
      t_reset();
      t_bad_sleep();
      t_nmi_wake();
      t_irq_wake();
      t_per_wake();
      t_reset_exit();
      t_standby();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_sub);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule